// File: doc/BRIEF.md
# PWM Output Event Shaper with Buffered Force

This block turns time-base events into two pulse-width-modulated outputs, A and B. A counter elsewhere reports four events: the count reached zero, the count reached the period, the count matched compare A while rising, and the count matched compare B while rising. The block acts only on cycles where the prescaled tick input is high. Each output has its own 16-bit action word that gives every event a 2-bit action code: nothing, drive low, drive high or toggle. When several events with live codes arrive on the same tick, a fixed priority picks the one that acts.

A continuous force word can hold either output low or high regardless of the events. Writes go to a shadow copy. The shadow is copied into the active force at a point chosen by a 2-bit reload select: at the zero event, at the period event, at either of them, or at the next tick. A force that is loaded on a tick already governs the output level produced on that same tick.

Top module: `pwm_event_shaper`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears both outputs to 0 and clears the shadow and active force words to 0. After reset no force is active.
- R2: The outputs change only on a clock edge where `tick` is 1. Events and reloads seen while `tick` is 0 have no effect.
- R3: Action codes: 2'b00 leaves the output unchanged, 2'b01 drives it to 0, 2'b10 drives it to 1, and 2'b11 inverts it. The new level is visible after the clock edge of the acting tick.
- R4: In each action word the zero event uses bits [1:0], the period event bits [3:2], the rising compare A event bits [5:4] and the rising compare B event bits [9:8]. All other bits are ignored.
- R5: When events coincide on one tick, the event with the highest priority whose code is not 2'b00 acts alone. The priority order from highest to lowest is compare B, compare A, period, zero.
- R6: The force word `force_wdata` is 4 bits wide: output A uses bits [1:0] and output B bits [3:2]. 2'b01 forces the output low, 2'b10 forces it high, and both 2'b00 and 2'b11 mean no force.
- R7: While a force is active on an output, that output takes the forced level on every tick and ignores all event actions.
- R8: A write (`force_wr`) updates only the shadow. The shadow moves into the active force on a tick that carries the event chosen by `reload_sel`: 2'd0 zero, 2'd1 period, 2'd2 zero or period. With 2'd3 it moves on the next tick, whatever the events. The loaded force already applies on that tick.
- R9: Suppose the zero action is set-high and the compare action is clear-low. If the compare value is 0, the compare event always coincides with the zero event, so the output stays low. If the compare value is beyond the period, the compare event never occurs, so the output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled tick; the outputs update only when it is 1 |
| ev_zero | input | 1 | Counter is at zero |
| ev_period | input | 1 | Counter is at the period |
| ev_cmpa_up | input | 1 | Counter equals compare A while counting up |
| ev_cmpb_up | input | 1 | Counter equals compare B while counting up |
| act_a | input | 16 | Action word for output A |
| act_b | input | 16 | Action word for output B |
| force_wr | input | 1 | Write strobe for the force shadow |
| force_wdata | input | 4 | Force value written to the shadow |
| reload_sel | input | 2 | Point at which the shadow is moved into the active force |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
Every result lives in an output register, so an event, action or force on a tick shows up right after that tick's clock edge. This is exactly one edge later, and no earlier edge shows it. A write to the force shadow shows nothing until a later tick reloads it. The bench drives each stimulus at a falling edge and compares the outputs at the next falling edge, one rising edge later. For the shadow it applies the write on a non-tick cycle, checks that the outputs are unchanged, and only then issues the reloading tick. The constant-level cases run a counter model in the bench and check after every tick edge of three full periods.

// File: rtl/pwm_es_pkg.sv
// Package: shared codes, event bundle and field positions for the
// PWM event shaper. Assumes 2-bit action and force codes.
package pwm_es_pkg;

    localparam int CODE_W = 2;

    // Bit offsets of each event's code inside an action word.
    localparam int ZERO_LSB = 0;
    localparam int PRD_LSB  = 2;
    localparam int CMPA_LSB = 4;
    localparam int CMPB_LSB = 8;

    typedef enum logic [CODE_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_code_e;

    typedef enum logic [CODE_W-1:0] {
        FRC_OFF0 = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_OFF3 = 2'b11
    } force_code_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'd0,
        RLD_PERIOD = 2'd1,
        RLD_EITHER = 2'd2,
        RLD_NOW    = 2'd3
    } reload_e;

    typedef struct packed {
        logic cmpb;
        logic cmpa;
        logic period;
        logic zero;
    } es_events_t;

endpackage

// File: rtl/es_event_resolve.sv
// Module: es_event_resolve
// Picks the action code that acts on one output for the current events.
// Priority from high to low: compare B, compare A, period, zero. An event
// whose code is "none" does not block a lower-priority one.
// Assumes ACT_W is at least CMPB_LSB + CODE_W. Purely combinational.
module es_event_resolve
    import pwm_es_pkg::*;
#(
    parameter int ACT_W = 16
) (
    input  es_events_t        events,
    input  logic [ACT_W-1:0]  act_word,
    output act_code_e         code
);

    localparam int NUM_EV = 4;

    // Per-event codes, index 0 is the lowest priority.
    logic [CODE_W-1:0] ev_code [NUM_EV];
    logic [NUM_EV-1:0] ev_live;

    assign ev_code[0] = act_word[ZERO_LSB +: CODE_W];
    assign ev_code[1] = act_word[PRD_LSB  +: CODE_W];
    assign ev_code[2] = act_word[CMPA_LSB +: CODE_W];
    assign ev_code[3] = act_word[CMPB_LSB +: CODE_W];

    logic [NUM_EV-1:0] ev_hit;
    assign ev_hit = {events.cmpb, events.cmpa, events.period, events.zero};

    // Mark events that are present and carry a real action.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_EV; gi++) begin : g_live
            assign ev_live[gi] = ev_hit[gi] && (ev_code[gi] != ACT_NONE);
        end
    endgenerate

    // Highest-priority live event wins; later loop passes override.
    always_comb begin
        code = ACT_NONE;
        for (int i = 0; i < NUM_EV; i++) begin
            if (ev_live[i]) code = act_code_e'(ev_code[i]);
        end
    end

endmodule

// File: rtl/es_force_buffer.sv
// Module: es_force_buffer
// Holds the shadow and active continuous-force words. A write lands in
// the shadow. The shadow moves into the active word on a tick that matches
// the reload select. The force that governs this tick comes out on
// eff_force: it is the freshly loaded shadow when a reload happens now.
// Assumes 2 bits of force per output.
module es_force_buffer
    import pwm_es_pkg::*;
#(
    parameter int NUM_OUT = 2,
    localparam int FW     = NUM_OUT * CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ev_zero,
    input  logic          ev_period,
    input  logic          wr,
    input  logic [FW-1:0] wdata,
    input  reload_e       sel,
    output logic [FW-1:0] eff_force
);

    logic [FW-1:0] shadow_q;
    logic [FW-1:0] active_q;
    logic          load_now;

    // Decide whether this tick moves the shadow into the active word.
    always_comb begin
        unique case (sel)
            RLD_ZERO:   load_now = tick && ev_zero;
            RLD_PERIOD: load_now = tick && ev_period;
            RLD_EITHER: load_now = tick && (ev_zero || ev_period);
            default:    load_now = tick;
        endcase
    end

    // Capture software writes into the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow_q <= '0;
        else if (wr) shadow_q <= wdata;
    end

    // Move the shadow into the active force at the chosen point.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_q <= '0;
        else if (load_now) active_q <= shadow_q;
    end

    assign eff_force = load_now ? shadow_q : active_q;

    // R1: reset clears both force words.
    a_r1_force_cleared: assert property (@(posedge clk)
        !rst_n |=> (shadow_q == '0) && (active_q == '0));

    // R2: the active force never moves without a tick.
    a_r2_active_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(active_q));

    // R8: immediate mode copies the shadow on any tick.
    a_r8_immediate_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == RLD_NOW) |=> (active_q == $past(shadow_q)));

    // R8: zero-mode reload holds without a zero event.
    a_r8_zero_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RLD_ZERO && !ev_zero) |=> $stable(active_q));

endmodule

// File: rtl/es_output_stage.sv
// Module: es_output_stage
// Registers one PWM output. On a tick an active force sets the level.
// Without a force, the resolved event action sets, clears, toggles or
// keeps it. Between ticks the level holds. Assumes force codes 00/11 mean
// no force.
module es_output_stage
    import pwm_es_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  act_code_e            act,
    input  logic [CODE_W-1:0]    frc,
    output logic                 q
);

    logic next_q;

    // Combine force and event action into the next level.
    always_comb begin
        unique case (frc)
            FRC_LOW:  next_q = 1'b0;
            FRC_HIGH: next_q = 1'b1;
            default: begin
                unique case (act)
                    ACT_LOW:    next_q = 1'b0;
                    ACT_HIGH:   next_q = 1'b1;
                    ACT_TOGGLE: next_q = ~q;
                    default:    next_q = q;
                endcase
            end
        endcase
    end

    // Update the output only on prescaled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (tick) q <= next_q;
    end

    // R1: output low after reset.
    a_r1_out_low: assert property (@(posedge clk) !rst_n |=> !q);

    // R2: no tick, no change.
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q));

    // R7: force low wins.
    a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc == FRC_LOW) |=> !q);

    // R7: force high wins.
    a_r7_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc == FRC_HIGH) |=> q);

    // R3: an unforced toggle inverts the output.
    a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (frc == FRC_OFF0 || frc == FRC_OFF3) && act == ACT_TOGGLE)
        |=> (q != $past(q)));

endmodule

// File: rtl/pwm_event_shaper.sv
// Module: pwm_event_shaper (top)
// Two PWM outputs driven by time-base events through per-output action
// words, with a double-buffered continuous force. Assumes the events are
// single-cycle pulses aligned with tick, and action words hold steady
// apart from deliberate reconfiguration.
module pwm_event_shaper
    import pwm_es_pkg::*;
#(
    parameter int ACT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ev_zero,
    input  logic             ev_period,
    input  logic             ev_cmpa_up,
    input  logic             ev_cmpb_up,
    input  logic [ACT_W-1:0] act_a,
    input  logic [ACT_W-1:0] act_b,
    input  logic             force_wr,
    input  logic [3:0]       force_wdata,
    input  logic [1:0]       reload_sel,
    output logic             pwm_a,
    output logic             pwm_b
);

    localparam int NUM_OUT = 2;
    localparam int FW      = NUM_OUT * CODE_W;

    es_events_t        events;
    logic [ACT_W-1:0]  act_words [NUM_OUT];
    logic [FW-1:0]     eff_force;
    logic [NUM_OUT-1:0] outs;

    assign events     = '{cmpb: ev_cmpb_up, cmpa: ev_cmpa_up,
                          period: ev_period, zero: ev_zero};
    assign act_words[0] = act_a;
    assign act_words[1] = act_b;

    es_force_buffer #(.NUM_OUT(NUM_OUT)) u_force (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ev_zero   (ev_zero),
        .ev_period (ev_period),
        .wr        (force_wr),
        .wdata     (force_wdata),
        .sel       (reload_e'(reload_sel)),
        .eff_force (eff_force)
    );

    // One resolver and one output register per channel.
    genvar gc;
    generate
        for (gc = 0; gc < NUM_OUT; gc++) begin : g_chan
            act_code_e code;

            es_event_resolve #(.ACT_W(ACT_W)) u_res (
                .events   (events),
                .act_word (act_words[gc]),
                .code     (code)
            );

            es_output_stage u_out (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .act   (code),
                .frc   (eff_force[gc*CODE_W +: CODE_W]),
                .q     (outs[gc])
            );
        end
    endgenerate

    assign pwm_a = outs[0];
    assign pwm_b = outs[1];

    // R5: a lone compare B set-high on a tick, no force, drives A high.
    a_r5_cmpb_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ev_cmpb_up && act_a[9:8] == 2'b10 &&
         eff_force[1:0] != 2'b01) |=> pwm_a);

endmodule

// File: tb/sim_pwm_event_shaper.sv
module sim_pwm_event_shaper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
    logic [15:0] act_a = '0, act_b = '0;
    logic        force_wr = 1'b0;
    logic [3:0]  force_wdata = '0;
    logic [1:0]  reload_sel = '0;
    logic        pwm_a, pwm_b;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    pwm_event_shaper u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ev_zero(ev_zero), .ev_period(ev_period),
        .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
        .act_a(act_a), .act_b(act_b),
        .force_wr(force_wr), .force_wdata(force_wdata),
        .reload_sel(reload_sel), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // Fields: req[49:46] tick[45] ev{cb,ca,prd,zro}[44:41] act_a[40:25]
    // act_b[24:9] fwr[8] fdata[7:4] rsel[3:2] exp_a[1] exp_b[0]
    localparam int NV = 17;
    localparam logic [49:0] VEC [NV] = '{
        {4'd3, 1'b1, 4'b0001, 16'h0002, 16'h0003, 1'b0, 4'h0, 2'd0, 1'b1, 1'b1}, // R3 set / toggle
        {4'd2, 1'b0, 4'b0100, 16'h0010, 16'h0010, 1'b0, 4'h0, 2'd0, 1'b1, 1'b1}, // R2 no tick
        {4'd3, 1'b1, 4'b0100, 16'h0010, 16'h0010, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0}, // R3 clear
        {4'd4, 1'b1, 4'b0010, 16'h0008, 16'h000C, 1'b0, 4'h0, 2'd0, 1'b1, 1'b1}, // R4 period field
        {4'd4, 1'b1, 4'b0010, 16'h00C4, 16'h00F3, 1'b0, 4'h0, 2'd0, 1'b0, 1'b1}, // R4 other bits ignored
        {4'd5, 1'b1, 4'b1111, 16'h0212, 16'h001A, 1'b0, 4'h0, 2'd0, 1'b1, 1'b0}, // R5 cmpb, then cmpa
        {4'd5, 1'b1, 4'b0011, 16'h0006, 16'h0002, 1'b0, 4'h0, 2'd0, 1'b0, 1'b1}, // R5 period over zero
        {4'd8, 1'b0, 4'b0000, 16'h0000, 16'h0000, 1'b1, 4'b1001, 2'd1, 1'b0, 1'b1}, // R8 write shadow
        {4'd8, 1'b1, 4'b0001, 16'h0002, 16'h0001, 1'b0, 4'h0, 2'd1, 1'b1, 1'b0}, // R8 zero: no reload
        {4'd7, 1'b1, 4'b0010, 16'h0008, 16'h0004, 1'b0, 4'h0, 2'd1, 1'b0, 1'b1}, // R7 period reload
        {4'd7, 1'b1, 4'b0001, 16'h0002, 16'h0001, 1'b0, 4'h0, 2'd1, 1'b0, 1'b1}, // R7 force holds
        {4'd8, 1'b0, 4'b0000, 16'h0000, 16'h0000, 1'b1, 4'b0110, 2'd3, 1'b0, 1'b1}, // R8 write
        {4'd8, 1'b1, 4'b0000, 16'h0000, 16'h0000, 1'b0, 4'h0, 2'd3, 1'b1, 1'b0}, // R8 immediate
        {4'd7, 1'b1, 4'b1000, 16'h0100, 16'h0200, 1'b0, 4'h0, 2'd3, 1'b1, 1'b0}, // R7 over cmpb
        {4'd6, 1'b0, 4'b0000, 16'h0000, 16'h0000, 1'b1, 4'b1100, 2'd2, 1'b1, 1'b0}, // R6 codes 11/00
        {4'd6, 1'b1, 4'b0010, 16'h0004, 16'h0008, 1'b0, 4'h0, 2'd2, 1'b0, 1'b1}, // R6 no force
        {4'd3, 1'b1, 4'b0001, 16'h0003, 16'h0003, 1'b0, 4'h0, 2'd0, 1'b1, 1'b0}  // R3 toggle
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic got_a, input logic got_b,
                         input logic exp_a, input logic exp_b);
        n_checks++;
        if (got_a !== exp_a || got_b !== exp_b) begin
            n_fail++;
            $display("FAIL %s: pwm_a/pwm_b actual %b%b expected %b%b",
                     req, got_a, got_b, exp_a, exp_b);
        end
    endtask

    task automatic idle();
        tick = 1'b0; force_wr = 1'b0;
        {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = 4'b0000;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state.
        step(); step();
        check("R1", pwm_a, pwm_b, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            v = VEC[i];
            tick = v[45];
            {ev_cmpb_up, ev_cmpa_up, ev_period, ev_zero} = v[44:41];
            act_a = v[40:25];
            act_b = v[24:9];
            force_wr = v[8];
            force_wdata = v[7:4];
            reload_sel = v[3:2];
            step();
            check($sformatf("R%0d vec %0d", v[49:46], i), pwm_a, pwm_b, v[1], v[0]);
        end
        idle();

        // R1: force both low, then reset must clear the force and outputs.
        force_wr = 1'b1; force_wdata = 4'b0101; reload_sel = 2'd3;
        step();
        force_wr = 1'b0; tick = 1'b1;
        step();
        check("R7 forced low", pwm_a, pwm_b, 1'b0, 1'b0);
        tick = 1'b0; rst_n = 1'b0;
        step();
        check("R1 reset mid-run", pwm_a, pwm_b, 1'b0, 1'b0);
        rst_n = 1'b1; reload_sel = 2'd1;
        act_a = 16'h0002; act_b = 16'h0002;
        tick = 1'b1; ev_zero = 1'b1;
        step();
        check("R1 force cleared", pwm_a, pwm_b, 1'b1, 1'b1);
        idle();

        // R9: counter model 0..5; compare A at 0, compare B at 7 (never).
        rst_n = 1'b0; step(); rst_n = 1'b1;
        reload_sel = 2'd0;
        act_a = 16'h0012;   // zero set-high, compare A clear
        act_b = 16'h0102;   // zero set-high, compare B clear
        for (int c = 0; c < 18; c++) begin
            int cnt;
            cnt = c % 6;
            tick = 1'b1;
            ev_zero    = (cnt == 0);
            ev_period  = (cnt == 5);
            ev_cmpa_up = (cnt == 0);
            ev_cmpb_up = (cnt == 7);
            step();
            check("R9 constant levels", pwm_a, pwm_b, 1'b0, 1'b1);
        end
        idle();
        step();
        finish_run();
    end

endmodule